// File: doc/BRIEF.md
# DDR3 Power-Up Command Sequencer

This block drives the mode-register bring-up of a DDR3 memory through the direct-command port of a memory controller. A one-cycle `start` pulse makes it raise a one-cycle power-up request. It then waits until the controller reports that power-up has finished. After that it issues seven commands in a fixed order, addressed to both chip selects at once.

Each command is a 32-bit word with a self-clearing start flag in bit 31. The sequencer pulses `cmd_wr` once per command and keeps the word steady. It does not move on until the controller's read-back of that flag (`cmd_pending`) has dropped. A programmable gap of about one microsecond follows the first command. The four mode-register values come in on ports. When the last command completes, `done` rises and stays high until the next start.

Top module: `ddr3_mrs_seq`

## Requirements
- R1: After reset `cmd_wr`, `pu_req` and `done` are 0 and `cmd_word` is all zeros.
- R2: A `start` pulse while idle or done gives exactly one cycle of `pu_req` on the next cycle. No command is written until `pu_done` has been seen high after that request, however long `pu_done` stays low.
- R3: Every written command word has bit 31 = 1, bits 30:22 = 0, rank bits 21:20 = 3, bank address in bits 19:17, a 13-bit address in bits 16:4 and the command code in bits 3:0.
- R4: The commands come in this order: deselect (code 0), precharge-all (code 1), mode-register-set (code 3) to bank 2 with `mr2`, to bank 3 with `mr3`, to bank 1 with `mr1`, to bank 0 with `mr0` with address bit 8 forced to 1, then ZQ long calibration (code 5). Non-MRS commands carry bank 0 and address 0.
- R5: `cmd_wr` lasts one cycle per command and is never high while `cmd_pending` is high. While `cmd_pending` stays high the word does not change. The controller raises `cmd_pending` in the cycle after the strobe.
- R6: The precharge-all strobe comes exactly GAP_CYC+1 cycles after the first cycle in which `cmd_pending` reads low after the deselect. GAP_CYC = ceil(CLK_MHZ*GAP_NS/1000), which is 250 at the defaults.
- R7: `done` rises in the cycle after `cmd_pending` clears for the ZQ command and holds until a new `start`. A `start` that arrives while the sequence runs is ignored: it gives no extra `pu_req` and no extra commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to run the sequence |
| pu_done | input | 1 | Controller power-up finished status |
| mr0 | input | 13 | Mode register 0 value |
| mr1 | input | 13 | Mode register 1 value |
| mr2 | input | 13 | Mode register 2 value |
| mr3 | input | 13 | Mode register 3 value |
| cmd_pending | input | 1 | Read-back of the command start flag |
| pu_req | output | 1 | One-cycle power-up start request |
| cmd_word | output | 32 | Command word to the controller |
| cmd_wr | output | 1 | Write strobe for `cmd_word` |
| done | output | 1 | Sequence complete |

## Verification
The sequence runs with several sets of mode-register values: distinct values, all ones and all zeros. These show whether each value reaches its own bank slot, and whether the DLL-reset bit is forced only into the bank-0 write. Controller clearing delays are tried both as zero extra cycles and as random up to several cycles. This separates a sequencer that waits for the flag from one that counts fixed cycles. Separate runs hold power-up-done low for a long time or already high, and inject a start pulse mid-run, to tell a correct request/ignore gate from a leaky one. The gap after the deselect is measured to the cycle.

// File: rtl/ddr3_mrs_seq.sv
module ddr3_mrs_seq #(
  parameter int CLK_MHZ     = 250,
  parameter int GAP_NS      = 1000,
  parameter int ADDR_W      = 13,
  parameter int BANK_LSB    = 17,
  parameter int ADDR_LSB    = 4,
  parameter int RANK_LSB    = 20,
  parameter int DLL_RST_BIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pu_done,
  input  logic [ADDR_W-1:0] mr0,
  input  logic [ADDR_W-1:0] mr1,
  input  logic [ADDR_W-1:0] mr2,
  input  logic [ADDR_W-1:0] mr3,
  input  logic              cmd_pending,
  output logic              pu_req,
  output logic [31:0]       cmd_word,
  output logic              cmd_wr,
  output logic              done
);
  localparam int GAP_RAW = (CLK_MHZ * GAP_NS + 999) / 1000;
  localparam int GAP_CYC = (GAP_RAW < 1) ? 1 : GAP_RAW;
  localparam int CNT_W   = $clog2(GAP_CYC + 1);
  localparam logic [2:0] LAST = 3'd6;

  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_PWAIT, S_ISSUE, S_HOLD, S_GAP, S_DONE
  } st_t;

  st_t             st;
  logic [2:0]      step;
  logic [CNT_W-1:0] cnt;
  logic [3:0]      code;
  logic [2:0]      bank;
  logic [ADDR_W-1:0] addr;

  always_comb begin
    code = 4'd0;
    bank = 3'd0;
    addr = '0;
    case (step)
      3'd1: code = 4'd1;
      3'd2: begin code = 4'd3; bank = 3'd2; addr = mr2; end
      3'd3: begin code = 4'd3; bank = 3'd3; addr = mr3; end
      3'd4: begin code = 4'd3; bank = 3'd1; addr = mr1; end
      3'd5: begin
        code = 4'd3;
        bank = 3'd0;
        addr = mr0 | ADDR_W'(1 << DLL_RST_BIT);
      end
      3'd6: code = 4'd5;
      default: ;
    endcase
  end

  wire active = (st == S_ISSUE) || (st == S_HOLD);

  assign cmd_word = active ? (32'h8000_0000 | (32'd3 << RANK_LSB) |
                              (32'(bank) << BANK_LSB) |
                              (32'(addr) << ADDR_LSB) | 32'(code))
                           : 32'd0;
  assign cmd_wr = (st == S_ISSUE);
  assign pu_req = (st == S_REQ);
  assign done   = (st == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      step <= 3'd0;
      cnt  <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE: if (start) st <= S_REQ;
        S_REQ: st <= S_PWAIT;
        S_PWAIT:
          if (pu_done) begin
            step <= 3'd0;
            st   <= S_ISSUE;
          end
        S_ISSUE: st <= S_HOLD;
        S_HOLD:
          if (!cmd_pending) begin
            if (step == 3'd0) begin
              cnt <= '0;
              st  <= S_GAP;
            end else if (step == LAST) begin
              st <= S_DONE;
            end else begin
              step <= step + 3'd1;
              st   <= S_ISSUE;
            end
          end
        S_GAP:
          if (cnt == CNT_W'(GAP_CYC - 1)) begin
            step <= 3'd1;
            st   <= S_ISSUE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module ddr3_mrs_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        cmd_pending,
  input logic        pu_req,
  input logic [31:0] cmd_word,
  input logic        cmd_wr,
  input logic        done
);
  assert_wr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |-> !cmd_pending);
  assert_wr_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> !cmd_wr);
  assert_word_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pending && $past(cmd_pending)) |-> $stable(cmd_word));
  assert_format_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |-> (cmd_word[31] && cmd_word[30:22] == 9'd0 && cmd_word[21:20] == 2'd3));
  assert_dll_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_word[3:0] == 4'd3 && cmd_word[19:17] == 3'd0) |-> cmd_word[12]);
  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pu_req |=> !pu_req);
  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!cmd_wr && !pu_req));
  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> pu_req);
endmodule

bind ddr3_mrs_seq ddr3_mrs_seq_chk u_chk (.*);

// File: tb/ddr3_mrs_seq_bench.sv
module ddr3_mrs_seq_bench;
  localparam int GAP_CYC = 250;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        pu_done = 1'b0;
  logic [12:0] mr0 = '0, mr1 = '0, mr2 = '0, mr3 = '0;
  logic        cmd_pending;
  logic        pu_req;
  logic [31:0] cmd_word;
  logic        cmd_wr;
  logic        done;

  always #2 clk = ~clk;

  ddr3_mrs_seq u_ddr3_mrs_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .pu_done(pu_done),
    .mr0(mr0), .mr1(mr1), .mr2(mr2), .mr3(mr3),
    .cmd_pending(cmd_pending), .pu_req(pu_req), .cmd_word(cmd_word),
    .cmd_wr(cmd_wr), .done(done)
  );

  int max_dly = 0;
  int pcnt = 0;
  int ovl = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      cmd_pending <= 1'b0;
      pcnt <= 0;
    end else if (cmd_wr) begin
      if (cmd_pending) ovl <= ovl + 1;
      cmd_pending <= 1'b1;
      pcnt <= $urandom_range(max_dly, 0);
    end else if (cmd_pending) begin
      if (pcnt == 0) cmd_pending <= 1'b0;
      else pcnt <= pcnt - 1;
    end
  end

  logic [31:0] log_w [0:63];
  int wr_cyc [0:63];
  int log_n = 0, req_n = 0, cyc = 0, phase = 0, clr_cyc = 0, ovl_hold = 0;
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (cmd_wr && log_n < 64) begin
      log_w[log_n] = cmd_word;
      wr_cyc[log_n] = cyc;
      log_n = log_n + 1;
    end
    if (pu_req) req_n = req_n + 1;
    if (cmd_wr && cmd_word[3:0] == 4'd0) phase = 1;
    else if (phase == 1 && cmd_pending) phase = 2;
    else if (phase == 2 && !cmd_pending) begin
      clr_cyc = cyc;
      phase = 0;
    end
  end

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expw(input int i);
    int code, bank;
    logic [12:0] a;
    code = 0; bank = 0; a = '0;
    case (i)
      1: code = 1;
      2: begin code = 3; bank = 2; a = mr2; end
      3: begin code = 3; bank = 3; a = mr3; end
      4: begin code = 3; bank = 1; a = mr1; end
      5: begin code = 3; bank = 0; a = mr0 | 13'h100; end
      6: code = 5;
      default: ;
    endcase
    return 32'h8000_0000 | (32'd3 << 20) | (32'(bank) << 17) | (32'(a) << 4) | 32'(code);
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk(!cmd_wr && !pu_req && !done, "R1 strobes idle", {cmd_wr, pu_req, done}, 0);
    chk(cmd_word == 0, "R1 word zero", cmd_word, 0);
  endtask

  task automatic t_run(input logic [12:0] m0, m1, m2, m3, input int dly,
                       input int pu_lag, input bit poke);
    int base, rq, w;
    bit preset;
    mr0 = m0; mr1 = m1; mr2 = m2; mr3 = m3; max_dly = dly;
    preset = (pu_lag == 0);
    pu_done = preset;
    base = log_n; rq = req_n;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(pu_req == 1'b1, "R2 request pulse", pu_req, 1);
    @(negedge clk);
    chk(pu_req == 1'b0, "R2 request one cycle", pu_req, 0);
    if (!preset) begin
      repeat (pu_lag) @(negedge clk);
      chk(log_n == base, "R2 no command before power-up done", log_n - base, 0);
      pu_done = 1'b1;
    end
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    w = 0;
    while (!done && w < 5000) begin @(negedge clk); w++; end
    pu_done = 1'b0;
    chk(done, "R7 done reached", done, 1);
    chk(log_n - base == 7, "R4 command count", log_n - base, 7);
    for (int i = 0; i < 7; i++)
      chk(log_w[base + i] == expw(i), $sformatf("R4 R3 command %0d", i),
          log_w[base + i], expw(i));
    chk(wr_cyc[base + 1] - clr_cyc == GAP_CYC + 1, "R6 gap after deselect",
        wr_cyc[base + 1] - clr_cyc, GAP_CYC + 1);
    chk(ovl == ovl_hold, "R5 no write while pending", ovl, ovl_hold);
    chk(req_n - rq == 1, "R7 single request per run", req_n - rq, 1);
    repeat (10) @(negedge clk);
    chk(done && log_n - base == 7, "R7 done holds, no extra commands",
        {done, 8'(log_n - base)}, {1'b1, 8'd7});
  endtask

  task automatic t_all();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_run(13'h0420, 13'h0042, 13'h0008, 13'h0000, 0, 30, 1'b0);
    t_run(13'h1fff, 13'h1fff, 13'h1fff, 13'h1fff, 6, 0, 1'b0);
    t_run(13'h0000, 13'h0000, 13'h0000, 13'h0000, 3, 200, 1'b1);
    t_run(13'h0a5a, 13'h15a5, 13'h0123, 13'h1321, 8, 5, 1'b1);
  endtask

  initial begin
    bit wd;
    wd = 1'b0;
    fork
      t_all();
      begin repeat (150000) @(negedge clk); wd = 1'b1; end
    join_any
    disable fork;
    if (wd) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule